// File: doc/BRIEF.md
# Serial Master Port with Per-Buffer Flush and Receive DMA Queue

This block is a byte-wide serial master. A small register bus programs it: address, write data, write strobe and a combinational read-data path. It drives a serial clock, a data-out line and an active-low select, and it samples a data-in line. Each word is 8 bits, sent most significant bit first. The serial clock idles low. Outgoing data is stable before each rising edge, and incoming data is captured on that rising edge. The serial clock period is an even multiple of the system clock.

Software uses the port in two ways. In the plain mode, a write to the transmit buffer starts a word, and the received word lands in a one-word receive buffer. In receive DMA mode, words are exchanged without software. The incoming words go into a 4-entry queue, and a word count register sets how many words are wanted. Once that count runs out, the port shifts five further words. They are kept only if the queue has room, so software has a control that switches DMA off and empties the queue. Software can empty each data buffer on its own without stopping the port. Clearing the enable bit stops the port and empties both buffers. The error flags are cleared by writing a one to them.

The shift engine is a four-state machine:
- IDLE: select high, clock low.
- LEAD: clock low, output bit presented.
- TRAIL: clock high, input bit already captured.
- END: one cycle that hands the finished word to the buffers.

Its transitions are:
- IDLE to LEAD when a word starts.
- LEAD to TRAIL after a half period, capturing the input bit.
- TRAIL to LEAD after a half period, moving to the next bit.
- TRAIL to END after the eighth bit.
- END to IDLE unconditionally.
- LEAD or TRAIL to IDLE when the port is disabled.

Top module: `spi_flush_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, cs_n is 1, sclk is 0 and irq is 0.
- R2: Writing control with bit 0 (enable) at 0 stops the port and empties both data buffers, so status bit 0 (receive full) and bit 1 (transmit full) read 0. While the port is disabled, writes to the transmit buffer (address 2) are ignored.
- R3: A write to address 2 while the port is enabled starts a word. The word goes out MSB first. The clock idles low, and input is captured on the rising edge. Each clock half lasts control[15:8]+1 system cycles. The received word is read at address 3 with status bit 0 set. Any write to address 3 releases the receive buffer.
- R4: Writing control with bit 19 set empties the receive buffer, and writing it with bit 18 set empties the transmit buffer. In both cases the port stays enabled and the bit reads back as 0. A flushed transmit word is never sent.
- R5: If a word completes in plain mode while the receive buffer is full, status bit 4 (overflow) is set. The new word is dropped and the buffer keeps its old word.
- R6: Writing 1 to status bit 4 or bit 5 clears that flag, and writing 0 to it has no effect. irq equals (status[4] AND control[1]) OR (status[5] AND control[2]).
- R7: A write to the DMA control register (address 4) with bit 7 set turns off DMA (bit 0 reads 0) and empties the queue (status[10:8] reads 0).
- R8: With DMA control bit 0 set and the count register (address 5) nonzero, words start on their own. Each received word enters the queue, and the count drops by one per word. Received words do not touch the receive buffer. Address 6 reads the oldest queued word, and a write to address 6 removes it. status[10:8] gives the queue fill level.
- R9: When the count reaches zero, five further words are shifted. Each is queued if there is room and otherwise dropped, with no error flag set.
- R10: If a word starts while the transmit buffer is empty, status bit 5 (underflow) is set and the previously sent word is shifted out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low for one word |
| irq | output | 1 | Masked error interrupt |

## Verification
The plain-mode exchange is tried with four transmit/reply byte pairs at four clock divide settings. Alternating bits, all-ones against all-zeros, and patterns with a single set bit at either end separate MSB-first from LSB-first order and show any bit lost or duplicated at the word edge. Counting the high-clock cycles confirms the divide setting. The DMA run uses an auto-incrementing reply from the slave model, so the queue contents reveal which words were kept: the two counted words and the first two run-on words. The total number of select pulses confirms that exactly five run-on words were shifted.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_END
    } shift_state_t;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DMAC = 3'd4;
    localparam logic [ADDR_W-1:0] A_DCNT = 3'd5;
    localparam logic [ADDR_W-1:0] A_DQUE = 3'd6;

    localparam int CB_EN      = 0;
    localparam int CB_IE_OVF  = 1;
    localparam int CB_IE_UDF  = 2;
    localparam int CB_DIV_LSB = 8;
    localparam int CB_TXFL    = 18;
    localparam int CB_RXFL    = 19;

    localparam int SB_RXF     = 0;
    localparam int SB_TXF     = 1;
    localparam int SB_BUSY    = 2;
    localparam int SB_OVF     = 4;
    localparam int SB_UDF     = 5;
    localparam int SB_LVL_LSB = 8;

    localparam int DB_EN  = 0;
    localparam int DB_CLR = 7;

endpackage

// File: rtl/spi_fc_shifter.sv
module spi_fc_shifter
    import spi_fc_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    shift_state_t st, st_nx;
    logic [DIV_W-1:0]  half_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic              half_hit;

    assign half_hit = (half_cnt == half_div);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start && !abort) st_nx = ST_LEAD;
            ST_LEAD:  if (abort) st_nx = ST_IDLE;
                      else if (half_hit) st_nx = ST_TRAIL;
            ST_TRAIL: if (abort) st_nx = ST_IDLE;
                      else if (half_hit) st_nx = (bit_cnt == LAST_BIT) ? ST_END : ST_LEAD;
            ST_END:   st_nx = ST_IDLE;
        endcase
    end

    // bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bit_cnt  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    half_cnt <= '0;
                    bit_cnt  <= '0;
                    if (start) tx_sh <= tx_word;
                end
                ST_LEAD: begin
                    if (half_hit) begin
                        half_cnt <= '0;
                        rx_sh    <= {rx_sh[WORD_W-2:0], miso};
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (half_hit) begin
                        half_cnt <= '0;
                        bit_cnt  <= bit_cnt + 1'b1;
                        tx_sh    <= {tx_sh[WORD_W-2:0], 1'b0};
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                ST_END: ;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        sclk    = (st == ST_TRAIL);
        cs_n    = !((st == ST_LEAD) || (st == ST_TRAIL));
        mosi    = cs_n ? 1'b0 : tx_sh[WORD_W-1];
        busy    = (st != ST_IDLE);
        done    = (st == ST_END);
        rx_word = rx_sh;
    end

endmodule

// File: rtl/spi_fc_fifo.sv
module spi_fc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                    mem[i] <= '0;
                else if (do_push && !clr && wp == PTR_W'(i))   mem[i] <= din;
            end
        end
    endgenerate

endmodule

// File: rtl/spi_flush_ctrl.sv
module spi_flush_ctrl
    import spi_fc_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int DIV_W       = 8,
    parameter int CNT_W       = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int RUNON_WORDS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_wr,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              irq
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int RUN_W = $clog2(RUNON_WORDS + 1);
    localparam logic [RUN_W-1:0] RUN_LOAD = RUN_W'(RUNON_WORDS);

    // control state
    logic             en_q, ie_ovf_q, ie_udf_q;
    logic [DIV_W-1:0] div_q;

    // buffers and flags
    logic [WORD_W-1:0] tx_buf_q, last_tx_q, rx_buf_q;
    logic              tx_full_q, rx_full_q, ovf_q, udf_q;

    // DMA state
    logic              dma_en_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RUN_W-1:0]  runon_q;

    // engine and queue wires
    logic              eng_start, eng_busy, eng_done;
    logic [WORD_W-1:0] eng_tx, eng_rx, q_head;
    logic [LVL_W-1:0]  q_level;
    logic              q_full, q_empty, q_push, q_pop, q_clr;

    logic wr_ctrl, wr_stat, wr_tx, wr_rx, wr_dmac, wr_cnt, wr_que;
    logic dma_active, counted, ovf_set, udf_set;
    logic kill_tx, kill_rx;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_tx   = reg_wr && (reg_addr == A_TXD);
    assign wr_rx   = reg_wr && (reg_addr == A_RXD);
    assign wr_dmac = reg_wr && (reg_addr == A_DMAC);
    assign wr_cnt  = reg_wr && (reg_addr == A_DCNT);
    assign wr_que  = reg_wr && (reg_addr == A_DQUE);

    assign counted    = (cnt_q != '0);
    assign dma_active = dma_en_q && (counted || (runon_q != '0));
    assign eng_start  = en_q && !eng_busy && (tx_full_q || dma_active);
    assign eng_tx     = tx_full_q ? tx_buf_q : last_tx_q;

    assign kill_tx = wr_ctrl && (!reg_wdata[CB_EN] || reg_wdata[CB_TXFL]);
    assign kill_rx = wr_ctrl && (!reg_wdata[CB_EN] || reg_wdata[CB_RXFL]);

    assign q_clr  = wr_dmac && reg_wdata[DB_CLR];
    assign q_push = eng_done && dma_active;
    assign q_pop  = wr_que;

    assign ovf_set = eng_done && (dma_active ? (counted && q_full) : rx_full_q);
    assign udf_set = eng_start && !tx_full_q;

    spi_fc_shifter #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .abort    (!en_q),
        .tx_word  (eng_tx),
        .half_div (div_q),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_word  (eng_rx)
    );

    spi_fc_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_clr),
        .push  (q_push),
        .din   (eng_rx),
        .pop   (q_pop),
        .head  (q_head),
        .level (q_level),
        .full  (q_full),
        .empty (q_empty)
    );

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            ie_ovf_q <= 1'b0;
            ie_udf_q <= 1'b0;
            div_q    <= '0;
        end else if (wr_ctrl) begin
            en_q     <= reg_wdata[CB_EN];
            ie_ovf_q <= reg_wdata[CB_IE_OVF];
            ie_udf_q <= reg_wdata[CB_IE_UDF];
            div_q    <= reg_wdata[CB_DIV_LSB +: DIV_W];
        end
    end

    // transmit buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf_q  <= '0;
            tx_full_q <= 1'b0;
            last_tx_q <= '0;
        end else begin
            if (eng_start && tx_full_q) begin
                tx_full_q <= 1'b0;
                last_tx_q <= tx_buf_q;
            end
            if (wr_tx && en_q) begin
                tx_buf_q  <= reg_wdata[WORD_W-1:0];
                tx_full_q <= 1'b1;
            end
            if (kill_tx) begin
                tx_buf_q  <= '0;
                tx_full_q <= 1'b0;
            end
        end
    end

    // receive buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf_q  <= '0;
            rx_full_q <= 1'b0;
        end else begin
            if (eng_done && !dma_active && !rx_full_q) begin
                rx_buf_q  <= eng_rx;
                rx_full_q <= 1'b1;
            end
            if (wr_rx) rx_full_q <= 1'b0;
            if (kill_rx) begin
                rx_buf_q  <= '0;
                rx_full_q <= 1'b0;
            end
        end
    end

    // sticky errors, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (wr_stat && reg_wdata[SB_OVF]) ovf_q <= 1'b0;
            if (wr_stat && reg_wdata[SB_UDF]) udf_q <= 1'b0;
            if (ovf_set) ovf_q <= 1'b1;
            if (udf_set) udf_q <= 1'b1;
        end
    end

    // DMA count and run-on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_en_q <= 1'b0;
            cnt_q    <= '0;
            runon_q  <= '0;
        end else begin
            if (eng_done && dma_active) begin
                if (counted) begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) runon_q <= RUN_LOAD;
                end else begin
                    runon_q <= runon_q - 1'b1;
                end
            end
            if (wr_cnt) begin
                cnt_q   <= reg_wdata[CNT_W-1:0];
                runon_q <= '0;
            end
            if (wr_dmac) begin
                dma_en_q <= reg_wdata[DB_EN] && !reg_wdata[DB_CLR];
                if (reg_wdata[DB_CLR]) begin
                    cnt_q   <= '0;
                    runon_q <= '0;
                end
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_EN]                 = en_q;
                reg_rdata[CB_IE_OVF]             = ie_ovf_q;
                reg_rdata[CB_IE_UDF]             = ie_udf_q;
                reg_rdata[CB_DIV_LSB +: DIV_W]   = div_q;
            end
            A_STAT: begin
                reg_rdata[SB_RXF]                = rx_full_q;
                reg_rdata[SB_TXF]                = tx_full_q;
                reg_rdata[SB_BUSY]               = eng_busy;
                reg_rdata[SB_OVF]                = ovf_q;
                reg_rdata[SB_UDF]                = udf_q;
                reg_rdata[SB_LVL_LSB +: LVL_W]   = q_level;
            end
            A_TXD:  reg_rdata[WORD_W-1:0] = tx_buf_q;
            A_RXD:  reg_rdata[WORD_W-1:0] = rx_buf_q;
            A_DMAC: reg_rdata[DB_EN]      = dma_en_q;
            A_DCNT: reg_rdata[CNT_W-1:0]  = cnt_q;
            A_DQUE: reg_rdata[WORD_W-1:0] = q_head;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (ovf_q && ie_ovf_q) || (udf_q && ie_udf_q);

endmodule

// File: rtl/spi_fc_checker.sv
module spi_fc_checker
    import spi_fc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        sclk,
    input logic        cs_n,
    input logic        rx_full,
    input logic        tx_full,
    input logic        ovf,
    input logic        dma_en,
    input logic [2:0]  level,
    input logic        done
);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R3

    AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[CB_EN]) |=> (!rx_full && !tx_full)); // R2

    AST_FLUSH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata[CB_RXFL:CB_TXFL] == 2'b00)); // R4

    AST_QUEUE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DMAC && reg_wdata[DB_CLR]) |=> (level == '0 && !dma_en)); // R7

    AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[SB_OVF] && !done) |=> !ovf); // R6

    AST_OVF_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !(reg_wr && (reg_addr == A_RXD || reg_addr == A_CTRL))) |=> rx_full); // R5

endmodule

bind spi_flush_ctrl spi_fc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .rx_full   (rx_full_q),
    .tx_full   (tx_full_q),
    .ovf       (ovf_q),
    .dma_en    (dma_en_q),
    .level     (q_level),
    .done      (eng_done)
);

// File: tb/tb_spi_flush_ctrl.sv
module tb_spi_flush_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso, cs_n, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_flush_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    // slave model, mode 0
    logic [7:0] slv_reply = 8'h00;
    logic [7:0] slv_out   = 8'h00;
    logic [7:0] slv_cap   = 8'h00;
    bit         slv_auto  = 0;
    int         frames    = 0;
    int         hi_cyc    = 0;

    always @(negedge cs_n) begin
        slv_out = slv_reply;
        frames++;
        if (slv_auto) slv_reply = slv_reply + 8'd1;
    end
    always @(posedge sclk) slv_cap = {slv_cap[6:0], mosi};
    always @(negedge sclk) slv_out = {slv_out[6:0], 1'b0};
    assign miso = slv_out[7];
    always @(negedge clk) if (sclk) hi_cyc++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rx();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd1, s);
            if (s[0]) break;
        end
    endtask

    // div, tx byte, reply byte
    localparam logic [23:0] VEC [4] = '{
        {8'd1, 8'hA5, 8'h3C},
        {8'd0, 8'h81, 8'h7E},
        {8'd3, 8'h00, 8'hFF},
        {8'd2, 8'hFF, 8'h01}
    };

    initial begin
        #400000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int f0;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(3'd0, r); chk("R1 ctrl", r, 32'h0);
        rd(3'd1, r); chk("R1 stat", r, 32'h0);
        chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R3 vector walk
        foreach (VEC[i]) begin
            wr(3'd0, 32'h1 | ({24'd0, VEC[i][23:16]} << 8));
            slv_auto = 0;
            slv_reply = VEC[i][7:0];
            hi_cyc = 0;
            wr(3'd2, {24'd0, VEC[i][15:8]});
            wait_rx();
            rd(3'd3, r); chk("R3 rx word", r, {24'd0, VEC[i][7:0]});
            chk("R3 tx word", {24'd0, slv_cap}, {24'd0, VEC[i][15:8]});
            chk("R3 sclk high cycles", hi_cyc, 8 * (VEC[i][23:16] + 1));
            wr(3'd3, 32'h0);
            rd(3'd1, r); chk("R3 release", {31'd0, r[0]}, 32'd0);
        end

        // R2 disable
        wr(3'd0, 32'h101);
        slv_reply = 8'h12;
        wr(3'd2, 32'h55);
        wait_rx();
        wr(3'd0, 32'h0);
        rd(3'd1, r); chk("R2 rx emptied", {31'd0, r[0]}, 32'd0);
        f0 = frames;
        wr(3'd2, 32'h66);
        idle(100);
        rd(3'd1, r); chk("R2 tx write ignored", {31'd0, r[1]}, 32'd0);
        chk("R2 no word sent", frames, f0);

        // R4 transmit flush
        wr(3'd0, 32'h101);
        slv_reply = 8'h34;
        f0 = frames;
        wr(3'd2, 32'h11);
        idle(5);
        wr(3'd2, 32'h22);
        rd(3'd1, r); chk("R4 tx full", {31'd0, r[1]}, 32'd1);
        wr(3'd0, 32'h101 | (32'h1 << 18));
        rd(3'd1, r); chk("R4 tx flushed", {31'd0, r[1]}, 32'd0);
        rd(3'd0, r); chk("R4 flush reads 0", r, 32'h101);
        wait_rx();
        idle(100);
        chk("R4 flushed word unsent", frames, f0 + 1);
        rd(3'd3, r); chk("R4 rx before flush", r, 32'h34);
        wr(3'd0, 32'h101 | (32'h1 << 19));
        rd(3'd1, r); chk("R4 rx flushed", {31'd0, r[0]}, 32'd0);
        rd(3'd3, r); chk("R4 rx data cleared", r, 32'h0);
        rd(3'd0, r); chk("R4 still enabled", {31'd0, r[0]}, 32'd1);

        // R5 overflow, R6 clear and mask
        slv_reply = 8'h3C;
        wr(3'd2, 32'hA1);
        wait_rx();
        slv_reply = 8'h99;
        wr(3'd2, 32'hA2);
        idle(100);
        rd(3'd1, r); chk("R5 overflow flag", {31'd0, r[4]}, 32'd1);
        rd(3'd3, r); chk("R5 old word kept", r, 32'h3C);
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'h103);
        idle(1);
        chk("R6 irq enabled", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h0);
        rd(3'd1, r); chk("R6 write 0 no effect", {31'd0, r[4]}, 32'd1);
        wr(3'd1, 32'h10);
        rd(3'd1, r); chk("R6 w1c clears", {31'd0, r[4]}, 32'd0);
        chk("R6 irq drops", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h0);

        // R8 R9 R10 receive DMA with run-on
        slv_auto = 1;
        slv_reply = 8'hC0;
        f0 = frames;
        wr(3'd5, 32'd2);
        wr(3'd4, 32'h1);
        idle(400);
        chk("R9 counted plus five run-on words", frames, f0 + 7);
        rd(3'd1, r);
        chk("R9 queue level", {29'd0, r[10:8]}, 32'd4);
        chk("R9 no overflow on run-on drop", {31'd0, r[4]}, 32'd0);
        chk("R10 underflow flag", {31'd0, r[5]}, 32'd1);
        chk("R8 rx buffer untouched", {31'd0, r[0]}, 32'd0);
        chk("R10 last word resent", {24'd0, slv_cap}, 32'hA2);
        rd(3'd6, r); chk("R8 queue head", r, 32'hC0);
        wr(3'd6, 32'h0);
        rd(3'd6, r); chk("R8 queue next", r, 32'hC1);
        rd(3'd1, r); chk("R8 level after pop", {29'd0, r[10:8]}, 32'd3);
        wr(3'd4, 32'h80);
        rd(3'd1, r); chk("R7 queue emptied", {29'd0, r[10:8]}, 32'd0);
        rd(3'd4, r); chk("R7 dma off", r, 32'h0);
        wr(3'd1, 32'h20);
        rd(3'd1, r); chk("R6 underflow w1c", {31'd0, r[5]}, 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule